// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block erases one block of a small-page, byte-wide NAND flash device on behalf of a host. The host presents a row address on a valid/ready port. Once the request is accepted, the sequencer drives the device's command, address and data lines from the system clock. It sends the erase-arm command, then three address bytes that carry the block part of the row only, then the erase-run command. A block spans 16 KB, and the whole block is erased.

After the run command the sequencer watches the device's ready line. It waits for the line to fall, meaning busy, and then to rise again, meaning ready. It then sends the status command and reads one status byte. It reports completion with a one-cycle done pulse and a fail flag. A timeout flag covers a device that never finishes.

Each bus cycle is paced by two programmable counts. The setup count sets how long the strobe stays low, and the hold count sets how long it stays high afterwards. The shared data bus is driven through a separate output, output enable and input.

Top module: `nand_erase_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the clock after the `done` pulse, so a request held valid meanwhile waits.
- R2: The first bus cycle of an erase is a write of byte 0x60 with `nf_cmd_en` high and `nf_addr_en` low.
- R3: Exactly three address write cycles follow, with `nf_addr_en` high and `nf_cmd_en` low. Bits 4..0 of the row (the page within the block) are forced to zero. The bytes are sent least significant first: masked row bits 7..0, then row bits 14..8 zero-extended, then 0x00.
- R4: The address cycles are followed by one write of byte 0xD0 with `nf_cmd_en` high.
- R5: Every bus cycle has three parts. One clock with both strobes high comes first, then the strobe low for `t_setup`+1 clocks, then high for `t_hold`+1 clocks. The latch enables and the driven byte stay constant through the whole cycle.
- R6: `nf_sel_n` is low from the clock after acceptance until the status read ends, and high while idle and during the `done` cycle.
- R7: After the 0xD0 cycle, the sequencer waits for `nf_rdy` to be seen low and then high. It then writes byte 0x70 with `nf_cmd_en` high.
- R8: The status read is one `nf_rd_n` cycle, timed as in R5, with `nf_dq_oe` low. The byte is sampled on the last clock of `nf_rd_n` low. `fail` equals bit 0 of that byte (1 = fail), and the other bits are ignored.
- R9: `done` is a one-clock pulse, and `fail` and `timeout` are valid in that clock.
- R10: The wait of R7 ends when `nf_rdy` returns high. If it has not returned BUSY_LIMIT+1 clocks after the 0xD0 cycle ends, `done` is raised with `fail`=1 and `timeout`=1, and no status command is sent.
- R11: `nf_wr_n` and `nf_rd_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_setup | input | CNT_W | Strobe-low length minus one, in clocks |
| t_hold | input | CNT_W | Strobe-high length minus one, in clocks |
| req_valid | input | 1 | Host erase request |
| req_ready | output | 1 | Sequencer can take a request |
| req_row | input | ROW_W | Row address of the block to erase |
| done | output | 1 | One-clock completion pulse |
| fail | output | 1 | Erase failed (valid with done) |
| timeout | output | 1 | Busy wait expired (valid with done) |
| nf_sel_n | output | 1 | Device select, active low |
| nf_cmd_en | output | 1 | Command latch enable |
| nf_addr_en | output | 1 | Address latch enable |
| nf_wr_n | output | 1 | Write strobe, active low |
| nf_rd_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Byte driven onto the data bus |
| nf_dq_oe | output | 1 | Data bus output enable |
| nf_dq_i | input | 8 | Byte read from the data bus |
| nf_rdy | input | 1 | Device ready (1) / busy (0), synchronous to clk |

## Verification
The bound checker watches these rules on every clock:
- the two strobes never overlap;
- the bus is released during reads;
- the latch enables are exclusive;
- the latch enables and the driven byte are stable while a strobe is low;
- device select is low under any strobe;
- `done` is a single pulse;
- a timeout always comes with a fail;
- the host hold-off follows R1.

Only the bench scenarios show the following:
- the exact order of the bytes and the masking of the page bits;
- the strobe lengths set by `t_setup`/`t_hold`;
- the wait on the ready line and its expiry with and without a busy phase;
- which status bit sets `fail`.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_ADDR,
      ST_RUN,
      ST_WAIT,
      ST_STAT,
      ST_READ,
      ST_DONE
   } seq_st_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_LOW,
      PH_HIGH
   } bus_ph_t;

   localparam logic [7:0] OP_ERASE_ARM = 8'h60;
   localparam logic [7:0] OP_ERASE_RUN = 8'hD0;
   localparam logic [7:0] OP_STATUS    = 8'h70;
   localparam int unsigned N_ADDR_CYC  = 3;

endpackage

// File: rtl/nand_bus_strobe.sv
module nand_bus_strobe
   import nand_erase_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             rd,
   input  logic [CNT_W-1:0] t_setup,
   input  logic [CNT_W-1:0] t_hold,
   input  logic [7:0]       din,
   output logic             idle,
   output logic             fin,
   output logic             wr_n,
   output logic             rd_n,
   output logic [7:0]       cap
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("nand_bus_strobe: CNT_W must be at least 1");
      end
   endgenerate

   bus_ph_t          ph;
   logic [CNT_W-1:0] cnt;
   logic             rd_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         cnt  <= '0;
         rd_l <= 1'b0;
         cap  <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (start) begin
               ph   <= PH_LOW;
               cnt  <= t_setup;
               rd_l <= rd;
            end
            PH_LOW: if (cnt == '0) begin
               ph  <= PH_HIGH;
               cnt <= t_hold;
               if (rd_l) cap <= din;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_HIGH: if (cnt == '0) ph <= PH_IDLE;
                     else           cnt <= cnt - 1'b1;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign idle = (ph == PH_IDLE);
   assign fin  = (ph == PH_HIGH) && (cnt == '0);
   assign wr_n = !((ph == PH_LOW) && !rd_l);
   assign rd_n = !((ph == PH_LOW) && rd_l);

endmodule

// File: rtl/nand_busy_watch.sv
module nand_busy_watch #(
   parameter int unsigned BUSY_LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic rdy,
   output logic ready_evt,
   output logic expire_evt
);

   localparam int unsigned TW = $clog2(BUSY_LIMIT + 1);
   localparam logic [1:0]  W_OFF  = 2'd0;
   localparam logic [1:0]  W_LOW  = 2'd1;
   localparam logic [1:0]  W_HIGH = 2'd2;

   generate
      if (BUSY_LIMIT < 1) begin : g_bad_limit
         $error("nand_busy_watch: BUSY_LIMIT must be at least 1");
      end
   endgenerate

   logic [1:0]    w_st;
   logic [TW-1:0] tcnt;

   assign ready_evt  = (w_st == W_HIGH) && rdy;
   assign expire_evt = (w_st != W_OFF) && !ready_evt && (tcnt == TW'(BUSY_LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_st <= W_OFF;
         tcnt <= '0;
      end else if (arm) begin
         w_st <= W_LOW;
         tcnt <= '0;
      end else if (ready_evt || expire_evt) begin
         w_st <= W_OFF;
      end else if (w_st != W_OFF) begin
         tcnt <= tcnt + 1'b1;
         if ((w_st == W_LOW) && !rdy) w_st <= W_HIGH;
      end
   end

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
   import nand_erase_pkg::*;
#(
   parameter int unsigned ROW_W      = 15,
   parameter int unsigned PAGE_BITS  = 5,
   parameter bit          MASK_PAGE  = 1'b1,
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned BUSY_LIMIT = 4096,
   parameter logic [7:0]  FAIL_MASK  = 8'h01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] t_setup,
   input  logic [CNT_W-1:0] t_hold,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [ROW_W-1:0] req_row,
   output logic             done,
   output logic             fail,
   output logic             timeout,
   output logic             nf_sel_n,
   output logic             nf_cmd_en,
   output logic             nf_addr_en,
   output logic             nf_wr_n,
   output logic             nf_rd_n,
   output logic [7:0]       nf_dq_o,
   output logic             nf_dq_oe,
   input  logic [7:0]       nf_dq_i,
   input  logic             nf_rdy
);

   localparam int unsigned AW  = 8 * N_ADDR_CYC;
   localparam int unsigned AIW = $clog2(N_ADDR_CYC);
   localparam logic [AIW-1:0] LAST_AIDX = AIW'(N_ADDR_CYC - 1);

   generate
      if (ROW_W > AW) begin : g_bad_row
         $error("nand_erase_seq: ROW_W does not fit the address cycles");
      end
      if (MASK_PAGE && (PAGE_BITS < 1 || PAGE_BITS >= ROW_W)) begin : g_bad_page
         $error("nand_erase_seq: PAGE_BITS out of range");
      end
   endgenerate

   seq_st_t          st;
   logic [ROW_W-1:0] row_q;
   logic [ROW_W-1:0] row_eff;
   logic [AW-1:0]    row_wide;
   logic [AIW-1:0]   aidx;
   logic             fail_q, tout_q;

   logic       bus_start, bus_rd, bus_idle, bus_fin;
   logic [7:0] bus_cap;
   logic       watch_arm, ready_evt, expire_evt;

   // Page-within-block bits: cleared or passed through
   generate
      if (MASK_PAGE) begin : g_mask
         localparam logic [ROW_W-1:0] KEEP = ~ROW_W'((1 << PAGE_BITS) - 1);
         assign row_eff = row_q & KEEP;
      end else begin : g_pass
         assign row_eff = row_q;
      end
   endgenerate

   assign row_wide = AW'(row_eff);

   // Sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         row_q  <= '0;
         aidx   <= '0;
         fail_q <= 1'b0;
         tout_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (req_valid) begin
               row_q  <= req_row;
               fail_q <= 1'b0;
               tout_q <= 1'b0;
               st     <= ST_ARM;
            end
            ST_ARM: if (bus_fin) begin
               aidx <= '0;
               st   <= ST_ADDR;
            end
            ST_ADDR: if (bus_fin) begin
               if (aidx == LAST_AIDX) st <= ST_RUN;
               else                   aidx <= aidx + 1'b1;
            end
            ST_RUN:  if (bus_fin) st <= ST_WAIT;
            ST_WAIT: if (ready_evt) begin
               st <= ST_STAT;
            end else if (expire_evt) begin
               fail_q <= 1'b1;
               tout_q <= 1'b1;
               st     <= ST_DONE;
            end
            ST_STAT: if (bus_fin) st <= ST_READ;
            ST_READ: if (bus_fin) begin
               fail_q <= |(bus_cap & FAIL_MASK);
               st     <= ST_DONE;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // Bus drive per state
   always_comb begin
      nf_cmd_en  = 1'b0;
      nf_addr_en = 1'b0;
      nf_dq_oe   = 1'b0;
      nf_dq_o    = 8'h00;
      bus_rd     = 1'b0;
      case (st)
         ST_ARM:  begin nf_cmd_en = 1'b1; nf_dq_oe = 1'b1; nf_dq_o = OP_ERASE_ARM; end
         ST_ADDR: begin nf_addr_en = 1'b1; nf_dq_oe = 1'b1; nf_dq_o = row_wide[8*aidx +: 8]; end
         ST_RUN:  begin nf_cmd_en = 1'b1; nf_dq_oe = 1'b1; nf_dq_o = OP_ERASE_RUN; end
         ST_STAT: begin nf_cmd_en = 1'b1; nf_dq_oe = 1'b1; nf_dq_o = OP_STATUS; end
         ST_READ: bus_rd = 1'b1;
         default: ;
      endcase
   end

   assign bus_start = bus_idle && (st inside {ST_ARM, ST_ADDR, ST_RUN, ST_STAT, ST_READ});
   assign watch_arm = (st == ST_RUN) && bus_fin;

   nand_bus_strobe #(.CNT_W(CNT_W)) u_bus (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (bus_start),
      .rd     (bus_rd),
      .t_setup(t_setup),
      .t_hold (t_hold),
      .din    (nf_dq_i),
      .idle   (bus_idle),
      .fin    (bus_fin),
      .wr_n   (nf_wr_n),
      .rd_n   (nf_rd_n),
      .cap    (bus_cap)
   );

   nand_busy_watch #(.BUSY_LIMIT(BUSY_LIMIT)) u_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (watch_arm),
      .rdy       (nf_rdy),
      .ready_evt (ready_evt),
      .expire_evt(expire_evt)
   );

   assign req_ready = (st == ST_IDLE);
   assign done      = (st == ST_DONE);
   assign fail      = fail_q;
   assign timeout   = tout_q;
   assign nf_sel_n  = (st == ST_IDLE) || (st == ST_DONE);

endmodule

// File: rtl/nand_erase_chk.sv
module nand_erase_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       done,
   input logic       fail,
   input logic       timeout,
   input logic       nf_sel_n,
   input logic       nf_cmd_en,
   input logic       nf_addr_en,
   input logic       nf_wr_n,
   input logic       nf_rd_n,
   input logic [7:0] nf_dq_o,
   input logic       nf_dq_oe
);

   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nf_wr_n && !nf_rd_n));

   p_bus_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_rd_n |-> !nf_dq_oe);

   p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      nf_addr_en |-> !nf_cmd_en);

   p_strobe_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!nf_wr_n && !$past(nf_wr_n)) |->
         ($stable(nf_dq_o) && $stable(nf_cmd_en) && $stable(nf_addr_en)));

   p_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!nf_wr_n || !nf_rd_n) |-> !nf_sel_n);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_timeout_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && timeout) |-> fail);

   p_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_holdoff_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !done) |=> !req_ready);

endmodule

bind nand_erase_seq nand_erase_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .fail      (fail),
   .timeout   (timeout),
   .nf_sel_n  (nf_sel_n),
   .nf_cmd_en (nf_cmd_en),
   .nf_addr_en(nf_addr_en),
   .nf_wr_n   (nf_wr_n),
   .nf_rd_n   (nf_rd_n),
   .nf_dq_o   (nf_dq_o),
   .nf_dq_oe  (nf_dq_oe)
);

// File: tb/tb_nand_erase_seq.sv
module tb_nand_erase_seq;

   localparam int CLK_PERIOD = 10;
   localparam int ROW_W      = 15;
   localparam int CNT_W      = 4;
   localparam int LIMIT      = 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic             req_valid = 1'b0;
   logic [ROW_W-1:0] req_row = '0;
   logic [CNT_W-1:0] cfg_s = '0, cfg_h = '0;
   logic             rdy = 1'b1;
   logic [7:0]       status_byte = 8'hE0;

   logic req_ready, done, fail, tout;
   logic sel_n, cmd_en, addr_en, wr_n, rd_n, dq_oe;
   logic [7:0] dq_o, dq_i;

   assign dq_i = !rd_n ? status_byte : 8'h00;

   nand_erase_seq #(.ROW_W(ROW_W), .CNT_W(CNT_W), .BUSY_LIMIT(LIMIT)) dut (
      .clk(clk), .rst_n(rst_n), .t_setup(cfg_s), .t_hold(cfg_h),
      .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
      .done(done), .fail(fail), .timeout(tout),
      .nf_sel_n(sel_n), .nf_cmd_en(cmd_en), .nf_addr_en(addr_en),
      .nf_wr_n(wr_n), .nf_rd_n(rd_n), .nf_dq_o(dq_o), .nf_dq_oe(dq_oe),
      .nf_dq_i(dq_i), .nf_rdy(rdy)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // Behavioural reference: expected port values after each rising edge
   logic e_sel = 1, e_cmd = 0, e_adr = 0, e_wr = 1, e_rd = 1, e_oe = 0;
   logic [7:0] e_dat = 0;
   logic e_rdy = 1, e_done = 0, e_fail = 0, e_tout = 0;

   task automatic m_cycle(input bit rd, input logic [7:0] b, input bit c, input bit a);
      e_sel = 0; e_cmd = c; e_adr = a; e_oe = !rd; e_dat = b;
      e_wr = 1; e_rd = 1; e_rdy = 0; e_done = 0;
      @(posedge clk);
      if (rd) e_rd = 0; else e_wr = 0;
      repeat (int'(cfg_s) + 1) @(posedge clk);
      e_wr = 1; e_rd = 1;
      repeat (int'(cfg_h) + 1) @(posedge clk);
   endtask

   function automatic logic [23:0] addr_bytes(input logic [ROW_W-1:0] r);
      return {9'b0, r[14:5], 5'b00000};
   endfunction

   initial begin
      logic [23:0] w;
      int t;
      bit hi_phase;
      bit ok;
      wait (rst_n);
      forever begin
         @(posedge clk);
         if (req_valid) begin
            w = addr_bytes(req_row);
            m_cycle(0, 8'h60, 1, 0);
            m_cycle(0, w[7:0], 0, 1);
            m_cycle(0, w[15:8], 0, 1);
            m_cycle(0, w[23:16], 0, 1);
            m_cycle(0, 8'hD0, 1, 0);
            e_cmd = 0; e_adr = 0; e_oe = 0; e_sel = 0;
            t = 0; hi_phase = 0; ok = 0;
            forever begin
               @(posedge clk);
               if (hi_phase && rdy) begin ok = 1; break; end
               if (t == LIMIT) break;
               if (!hi_phase && !rdy) hi_phase = 1;
               t++;
            end
            if (ok) begin
               m_cycle(0, 8'h70, 1, 0);
               m_cycle(1, 8'h00, 0, 0);
               e_fail = status_byte[0]; e_tout = 0;
            end else begin
               e_fail = 1; e_tout = 1;
            end
            e_sel = 1; e_cmd = 0; e_adr = 0; e_oe = 0; e_wr = 1; e_rd = 1;
            e_done = 1; e_rdy = 0;
            @(posedge clk);
            e_done = 0; e_rdy = 1;
         end
      end
   end

   // Compare every clock, away from the active edge
   initial begin
      wait (rst_n);
      forever begin
         @(negedge clk);
         check("R6 nf_sel_n", 8'(sel_n), 8'(e_sel));
         check("R2 nf_cmd_en", 8'(cmd_en), 8'(e_cmd));
         check("R3 nf_addr_en", 8'(addr_en), 8'(e_adr));
         check("R5 nf_wr_n", 8'(wr_n), 8'(e_wr));
         check("R8 nf_rd_n", 8'(rd_n), 8'(e_rd));
         check("R8 nf_dq_oe", 8'(dq_oe), 8'(e_oe));
         if (e_oe) check("R3 nf_dq_o", dq_o, e_dat);
         check("R1 req_ready", 8'(req_ready), 8'(e_rdy));
         check("R9 done", 8'(done), 8'(e_done));
         if (e_done) begin
            check("R8 fail", 8'(fail), 8'(e_fail));
            check("R10 timeout", 8'(tout), 8'(e_tout));
         end
         check("R11 strobe overlap", 8'(!wr_n && !rd_n), 8'h00);
      end
   end

   // Log of bytes written, taken at each falling write strobe
   logic [7:0] wlog[$];
   initial begin
      logic prev;
      prev = 1'b1;
      forever begin
         @(negedge clk);
         if (prev && !wr_n) wlog.push_back(dq_o);
         prev = wr_n;
      end
   end

   // Device ready/busy behaviour
   int dev_pre = 2, dev_len = 8;
   bit dev_nobusy = 0, dev_stuck = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (!wr_n && cmd_en && dq_o == 8'hD0) begin
            while (!wr_n) @(negedge clk);
            if (!dev_nobusy) begin
               repeat (dev_pre) @(negedge clk);
               rdy = 1'b0;
               if (dev_stuck) begin
                  while (!done) @(negedge clk);
               end else begin
                  repeat (dev_len) @(negedge clk);
               end
               rdy = 1'b1;
            end
         end
      end
   end

   task automatic submit(input logic [ROW_W-1:0] row);
      @(negedge clk);
      req_valid = 1'b1; req_row = row;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish(input logic [ROW_W-1:0] row, input bit ef, input bit et);
      logic [23:0] w;
      w = addr_bytes(row);
      while (!done) @(negedge clk);
      check("R8 R10 fail flag", 8'(fail), 8'(ef));
      check("R10 timeout flag", 8'(tout), 8'(et));
      check("R7 byte count", 8'(wlog.size()), et ? 8'd5 : 8'd6);
      if (wlog.size() >= 5) begin
         check("R2 arm byte", wlog[0], 8'h60);
         check("R3 addr byte 0", wlog[1], w[7:0]);
         check("R3 addr byte 1", wlog[2], w[15:8]);
         check("R3 addr byte 2", wlog[3], w[23:16]);
         check("R4 run byte", wlog[4], 8'hD0);
      end
      if (!et && wlog.size() == 6) check("R7 status cmd", wlog[5], 8'h70);
      wlog.delete();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R6 reset nf_sel_n", 8'(sel_n), 8'h01);
      check("R1 reset req_ready", 8'(req_ready), 8'h01);
      check("R5 reset nf_wr_n", 8'(wr_n), 8'h01);
      check("R8 reset nf_rd_n", 8'(rd_n), 8'h01);
      check("R9 reset done", 8'(done), 8'h00);
      rst_n = 1'b1;

      // Pass, page bits set, fastest timing
      cfg_s = 0; cfg_h = 0; status_byte = 8'hE0; dev_pre = 2; dev_len = 10;
      submit(15'h7FFF);
      finish(15'h7FFF, 0, 0);

      // Fail reported by bit 0
      cfg_s = 2; cfg_h = 1; status_byte = 8'hE1; dev_pre = 0; dev_len = 3;
      submit(15'h1234);
      finish(15'h1234, 1, 0);

      // Other status bits ignored, second request held off (R1)
      cfg_s = 1; cfg_h = 3; status_byte = 8'hFE; dev_pre = 1; dev_len = 6;
      @(negedge clk);
      req_valid = 1'b1; req_row = 15'h0021;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_row = 15'h4A5F;
      finish(15'h0021, 0, 0);
      status_byte = 8'hE0;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      finish(15'h4A5F, 0, 0);

      // Device never goes busy: timeout
      cfg_s = 0; cfg_h = 1; dev_nobusy = 1;
      submit(15'h0100);
      finish(15'h0100, 1, 1);

      // Device stays busy: timeout
      dev_nobusy = 0; dev_stuck = 1; dev_pre = 1;
      submit(15'h7E3C);
      finish(15'h7E3C, 1, 1);

      // Recovery after timeouts
      dev_stuck = 0; cfg_s = 3; cfg_h = 0; status_byte = 8'hE0; dev_pre = 0; dev_len = 4;
      submit(15'h0042);
      finish(15'h0042, 0, 0);

      repeat (5) @(negedge clk);
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule